// File: doc/BRIEF.md
# Privilege-Gated Hypervisor Register Port

This block holds one 64-bit hypervisor-level system register and decides what happens to each move-to or move-from request for it. The decision uses the requester's current privilege level (0 to 3), whether level 2 exists and is enabled, and two nested-virtualization control bits: a primary bit and a secondary bit. Each accepted request ends in exactly one of four outcomes. It is a direct register access, a memory request redirected to a fixed offset from a supplied base, a trap to level 2 carrying a syndrome class, or an undefined-instruction indication.

Direct accesses finish in a single cycle. A redirected access drives a valid/ready memory request. For a read, it then waits for a separate response-valid from memory before it returns the data. While a redirect is in flight the block lowers its request-ready and accepts nothing new. Exception entry and the memory subsystem sit outside the block.

Top module: `tbase_port`

## Requirements
- R1: Any request accepted at privilege level 0 produces only the undefined outcome pulse.
- R2: At level 1 with level 2 implemented and enabled and both nested bits set, the request is redirected. `mem_valid_o` rises with `mem_addr_o` = `mem_base_i` + 0x020 (modulo 2^ADDR_W), `mem_write_o` equal to the request's write flag, and `mem_wdata_o` equal to the write data for writes.
- R3: At level 1 with level 2 implemented and enabled, primary bit set and secondary bit clear, the request traps. `trap_o` pulses with `trap_class_o` = 6'h18.
- R4: Every other level 1 request is undefined. This covers a clear primary bit, level 2 disabled, and level 2 not implemented.
- R5: At level 2 with level 2 implemented, or at level 3 with level 2 implemented, the access is direct. A read returns the register on `rsp_rdata_o` with `rsp_valid_o`. A write replaces all 64 bits.
- R6: With level 2 not implemented, a level 3 access is direct: reads return zero and writes leave the register unchanged. A level 2 access is undefined.
- R7: A redirect holds `mem_valid_o` and its address stable until `mem_ready_i` is sampled high, and keeps `req_ready_o` low until completion. A write completes at the handshake. A read returns `mem_rdata_i` on `rsp_rdata_o` with `rsp_valid_o` one cycle after `mem_rvalid_i`.
- R8: Each accepted request yields exactly one of `out_direct_o`, `out_redir_o`, `out_trap_o`, `out_undef_o` for one cycle, in the cycle after acceptance. None of them is high at any other time.
- R9: After reset the register is zero, `req_ready_o` is high, and every outcome and memory output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| priv_lvl_i | input | 2 | Current privilege level of the requester |
| lvl2_impl_i | input | 1 | Level 2 is implemented |
| lvl2_en_i | input | 1 | Level 2 is enabled in the current state |
| nest_pri_i | input | 1 | Primary nested-virtualization bit |
| nest_sec_i | input | 1 | Secondary nested-virtualization bit |
| req_valid_i | input | 1 | Access request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_wdata_i | input | DATA_W | Write data |
| mem_base_i | input | ADDR_W | Base address for redirected accesses |
| mem_valid_o | output | 1 | Redirected memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_write_o | output | 1 | Redirected request is a write |
| mem_addr_o | output | ADDR_W | Redirected request address |
| mem_wdata_o | output | DATA_W | Redirected write data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DATA_W | Memory read data |
| rsp_valid_o | output | 1 | Read data valid to requester |
| rsp_rdata_o | output | DATA_W | Read data to requester |
| out_direct_o | output | 1 | Outcome pulse: direct access |
| out_redir_o | output | 1 | Outcome pulse: memory redirect |
| out_trap_o | output | 1 | Outcome pulse: trap to level 2 |
| out_undef_o | output | 1 | Outcome pulse: undefined instruction |
| trap_class_o | output | 6 | Syndrome class, valid with `out_trap_o` |

## Verification
The bench drives a request half a cycle before a rising edge and samples at the following falling edge. That is where the outcome pulses, the trap class, direct read data and the first cycle of `mem_valid_o` all become due, one register after acceptance. A redirected write is checked for completion one cycle after the edge on which `mem_ready_i` was high. A redirected read returns its data one cycle after the edge carrying `mem_rvalid_i`. During random ready stalls the request is checked each cycle to hold its address. Register contents are tracked in a bench shadow, and every direct read, including those after trapped, undefined and ignored writes, is compared with it.

// File: rtl/tbase_port_pkg.sv
package tbase_port_pkg;
  typedef enum logic [1:0] {
    ROUTE_DIRECT = 2'd0,
    ROUTE_REDIR  = 2'd1,
    ROUTE_TRAP   = 2'd2,
    ROUTE_UNDEF  = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    MST_IDLE = 2'd0,
    MST_REQ  = 2'd1,
    MST_RSP  = 2'd2
  } mst_e;
endpackage

// File: rtl/tbase_access_router.sv
module tbase_access_router
  import tbase_port_pkg::*;
(
  input  logic [1:0] priv_lvl_i,
  input  logic       lvl2_impl_i,
  input  logic       lvl2_en_i,
  input  logic       nest_pri_i,
  input  logic       nest_sec_i,
  output route_e     route_o,
  output logic       zero_view_o
);
  logic lvl2_on;
  assign lvl2_on = lvl2_impl_i & lvl2_en_i;

  always_comb begin
    route_o = ROUTE_UNDEF;
    unique case (priv_lvl_i)
      2'd0: route_o = ROUTE_UNDEF;
      2'd1: begin
        if (lvl2_on && nest_pri_i && nest_sec_i) route_o = ROUTE_REDIR;
        else if (lvl2_on && nest_pri_i)          route_o = ROUTE_TRAP;
        else                                     route_o = ROUTE_UNDEF;
      end
      2'd2: route_o = lvl2_impl_i ? ROUTE_DIRECT : ROUTE_UNDEF;
      2'd3: route_o = ROUTE_DIRECT;
      default: route_o = ROUTE_UNDEF;
    endcase
  end

  // level 3 sees a zero register when level 2 is absent
  assign zero_view_o = (priv_lvl_i == 2'd3) && !lvl2_impl_i;
endmodule

// File: rtl/tbase_store.sv
module tbase_store #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/tbase_redirect_ctrl.sv
module tbase_redirect_ctrl
  import tbase_port_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DATA_W = 64,
  parameter int OFFSET = 32'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              busy_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  localparam logic [ADDR_W-1:0] OffA = ADDR_W'(OFFSET);

  mst_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= MST_IDLE;
      mem_valid_o <= 1'b0;
      mem_write_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        MST_IDLE: if (start_i) begin
          mem_valid_o <= 1'b1;
          mem_write_o <= write_i;
          mem_addr_o  <= base_i + OffA;
          mem_wdata_o <= write_i ? wdata_i : '0;
          st_q        <= MST_REQ;
        end
        MST_REQ: if (mem_ready_i) begin
          mem_valid_o <= 1'b0;
          st_q        <= mem_write_o ? MST_IDLE : MST_RSP;
        end
        MST_RSP: if (mem_rvalid_i) begin
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= mem_rdata_i;
          st_q        <= MST_IDLE;
        end
        default: st_q <= MST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != MST_IDLE);
endmodule

// File: rtl/tbase_port.sv
module tbase_port
  import tbase_port_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 48,
  parameter int REDIR_OFF  = 32'h20,
  parameter int CLASS_W    = 6,
  parameter int TRAP_CLASS = 6'h18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         priv_lvl_i,
  input  logic               lvl2_impl_i,
  input  logic               lvl2_en_i,
  input  logic               nest_pri_i,
  input  logic               nest_sec_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  input  logic [ADDR_W-1:0]  mem_base_i,
  output logic               mem_valid_o,
  input  logic               mem_ready_i,
  output logic               mem_write_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic               mem_rvalid_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               out_direct_o,
  output logic               out_redir_o,
  output logic               out_trap_o,
  output logic               out_undef_o,
  output logic [CLASS_W-1:0] trap_class_o
);
  route_e            route;
  logic              zero_view;
  logic              fire;
  logic              busy;
  logic              store_we;
  logic [DATA_W-1:0] store_q;
  logic              red_rsp_valid;
  logic [DATA_W-1:0] red_rsp_rdata;
  logic              dir_rsp_q;
  logic [DATA_W-1:0] dir_rdata_q;

  assign req_ready_o = !busy;
  assign fire        = req_valid_i && req_ready_o;

  tbase_access_router u_router (
    .priv_lvl_i  (priv_lvl_i),
    .lvl2_impl_i (lvl2_impl_i),
    .lvl2_en_i   (lvl2_en_i),
    .nest_pri_i  (nest_pri_i),
    .nest_sec_i  (nest_sec_i),
    .route_o     (route),
    .zero_view_o (zero_view)
  );

  assign store_we = fire && (route == ROUTE_DIRECT) && req_write_i && !zero_view;

  tbase_store #(.DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (store_we),
    .wdata_i (req_wdata_i),
    .q_o     (store_q)
  );

  tbase_redirect_ctrl #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFFSET (REDIR_OFF)
  ) u_redir (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (fire && (route == ROUTE_REDIR)),
    .write_i      (req_write_i),
    .wdata_i      (req_wdata_i),
    .base_i       (mem_base_i),
    .busy_o       (busy),
    .mem_valid_o  (mem_valid_o),
    .mem_ready_i  (mem_ready_i),
    .mem_write_o  (mem_write_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rsp_valid_o  (red_rsp_valid),
    .rsp_rdata_o  (red_rsp_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_direct_o <= 1'b0;
      out_redir_o  <= 1'b0;
      out_trap_o   <= 1'b0;
      out_undef_o  <= 1'b0;
      trap_class_o <= '0;
      dir_rsp_q    <= 1'b0;
      dir_rdata_q  <= '0;
    end else begin
      out_direct_o <= fire && (route == ROUTE_DIRECT);
      out_redir_o  <= fire && (route == ROUTE_REDIR);
      out_trap_o   <= fire && (route == ROUTE_TRAP);
      out_undef_o  <= fire && (route == ROUTE_UNDEF);
      trap_class_o <= (fire && (route == ROUTE_TRAP)) ? CLASS_W'(TRAP_CLASS) : '0;
      dir_rsp_q    <= fire && (route == ROUTE_DIRECT) && !req_write_i;
      dir_rdata_q  <= zero_view ? '0 : store_q;
    end
  end

  // direct and redirect responses never coincide: redirect returns while busy
  assign rsp_valid_o = dir_rsp_q | red_rsp_valid;
  assign rsp_rdata_o = red_rsp_valid ? red_rsp_rdata : (dir_rsp_q ? dir_rdata_q : '0);
endmodule

// File: rtl/tbase_port_chk.sv
module tbase_port_chk #(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 48,
  parameter int REDIR_OFF  = 32'h20,
  parameter int CLASS_W    = 6,
  parameter int TRAP_CLASS = 6'h18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         priv_lvl_i,
  input logic               lvl2_impl_i,
  input logic               lvl2_en_i,
  input logic               nest_pri_i,
  input logic               nest_sec_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  mem_base_i,
  input logic               mem_valid_o,
  input logic               mem_ready_i,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_rvalid_i,
  input logic [DATA_W-1:0]  mem_rdata_i,
  input logic               rsp_valid_o,
  input logic [DATA_W-1:0]  rsp_rdata_o,
  input logic               out_direct_o,
  input logic               out_redir_o,
  input logic               out_trap_o,
  input logic               out_undef_o,
  input logic [CLASS_W-1:0] trap_class_o
);
  logic fire;
  assign fire = req_valid_i && req_ready_o;

  p_lvl0_undef_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && priv_lvl_i == 2'd0 |=> out_undef_o);

  p_redir_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && priv_lvl_i == 2'd1 && lvl2_impl_i && lvl2_en_i && nest_pri_i && nest_sec_i
    |=> mem_valid_o && mem_addr_o == ADDR_W'($past(mem_base_i) + ADDR_W'(REDIR_OFF)));

  p_trap_class_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && priv_lvl_i == 2'd1 && lvl2_impl_i && lvl2_en_i && nest_pri_i && !nest_sec_i
    |=> out_trap_o && trap_class_o == CLASS_W'(TRAP_CLASS));

  p_lvl1_undef_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && priv_lvl_i == 2'd1 && !(lvl2_impl_i && lvl2_en_i && nest_pri_i) |=> out_undef_o);

  p_noimpl_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && priv_lvl_i == 2'd3 && !lvl2_impl_i && !req_write_i
    |=> rsp_valid_o && rsp_rdata_o == '0);

  p_mem_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));

  p_busy_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !req_ready_o);

  p_rsp_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i && !req_ready_o && !mem_valid_o |=> rsp_valid_o && rsp_rdata_o == $past(mem_rdata_i));

  p_one_outcome_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_direct_o, out_redir_o, out_trap_o, out_undef_o}));

  p_outcome_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> !(out_direct_o || out_redir_o || out_trap_o || out_undef_o));
endmodule

bind tbase_port tbase_port_chk #(
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .REDIR_OFF  (REDIR_OFF),
  .CLASS_W    (CLASS_W),
  .TRAP_CLASS (TRAP_CLASS)
) u_chk (.*);

// File: tb/tbase_port_bench.sv
`timescale 1ns/1ps
module tbase_port_bench;
  localparam int DW = 64;
  localparam int AW = 48;
  localparam int RT_DIRECT = 0, RT_REDIR = 1, RT_TRAP = 2, RT_UNDEF = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    priv_lvl_i = '0;
  logic          lvl2_impl_i = 1'b0, lvl2_en_i = 1'b0, nest_pri_i = 1'b0, nest_sec_i = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [AW-1:0] mem_base_i = '0;
  logic          mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          req_ready_o, mem_valid_o, mem_write_o, rsp_valid_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o, rsp_rdata_o;
  logic          out_direct_o, out_redir_o, out_trap_o, out_undef_o;
  logic [5:0]    trap_class_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] shadow = '0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tbase_port u_tbase_port (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int exp_route(input logic [1:0] pv, input logic im, en, pr, se);
    if (pv == 2'd0) return RT_UNDEF;
    if (pv == 2'd1) begin
      if (im && en && pr && se) return RT_REDIR;
      if (im && en && pr)       return RT_TRAP;
      return RT_UNDEF;
    end
    if (pv == 2'd2) return im ? RT_DIRECT : RT_UNDEF;
    return RT_DIRECT;
  endfunction

  function automatic string req_tag(input int rt, input logic [1:0] pv, input logic im);
    if (pv == 2'd0) return "R1";
    if (rt == RT_REDIR) return "R2";
    if (rt == RT_TRAP) return "R3";
    if (pv == 2'd1) return "R4";
    if (!im) return "R6";
    return "R5";
  endfunction

  task automatic do_req(input logic [1:0] pv, input logic im, en, pr, se, wr,
                        input logic [DW-1:0] wd);
    int rt;
    string tg;
    logic [AW-1:0] base;
    logic [AW-1:0] exp_addr;
    logic [DW-1:0] rd;
    logic [3:0] exp_oh;
    rt = exp_route(pv, im, en, pr, se);
    tg = req_tag(rt, pv, im);
    base = {16'($urandom), 32'($urandom)};
    exp_addr = base + AW'(32'h20);
    @(negedge clk_i);
    priv_lvl_i = pv; lvl2_impl_i = im; lvl2_en_i = en; nest_pri_i = pr; nest_sec_i = se;
    req_write_i = wr; req_wdata_i = wd; mem_base_i = base; req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    exp_oh = 4'b1000 >> rt;
    chk({out_direct_o, out_redir_o, out_trap_o, out_undef_o} == exp_oh, "R8", "outcome",
        DW'({out_direct_o, out_redir_o, out_trap_o, out_undef_o}), DW'(exp_oh));
    case (rt)
      RT_DIRECT: begin
        if (!wr) begin
          chk(rsp_valid_o && rsp_rdata_o == ((pv == 2'd3 && !im) ? '0 : shadow), tg,
              "direct read", rsp_rdata_o, (pv == 2'd3 && !im) ? '0 : shadow);
        end else begin
          chk(!rsp_valid_o, tg, "no rsp on write", DW'(rsp_valid_o), '0);
          if (im) shadow = wd;
        end
      end
      RT_REDIR: begin
        chk(mem_valid_o && mem_addr_o == exp_addr && mem_write_o == wr && !req_ready_o,
            "R2", "redirect addr", DW'(mem_addr_o), DW'(exp_addr));
        if (wr) chk(mem_wdata_o == wd, "R2", "redirect wdata", mem_wdata_o, wd);
        for (int i = 0; i < int'($urandom % 4); i++) begin
          @(posedge clk_i); @(negedge clk_i);
          chk(mem_valid_o && mem_addr_o == exp_addr && !req_ready_o, "R7", "hold in stall",
              DW'(mem_addr_o), DW'(exp_addr));
        end
        mem_ready_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        mem_ready_i = 1'b0;
        chk(!mem_valid_o, "R7", "valid drops", DW'(mem_valid_o), '0);
        if (wr) begin
          chk(req_ready_o, "R7", "write done", DW'(req_ready_o), 1);
        end else begin
          chk(!req_ready_o, "R7", "await rsp", DW'(req_ready_o), 0);
          for (int i = 0; i < int'($urandom % 3); i++) begin
            @(posedge clk_i); @(negedge clk_i);
            chk(!rsp_valid_o && !req_ready_o, "R7", "no early rsp", DW'(rsp_valid_o), 0);
          end
          rd = {$urandom, $urandom};
          mem_rvalid_i = 1'b1; mem_rdata_i = rd;
          @(posedge clk_i); @(negedge clk_i);
          mem_rvalid_i = 1'b0;
          chk(rsp_valid_o && rsp_rdata_o == rd && req_ready_o, "R7", "redirect read data",
              rsp_rdata_o, rd);
        end
      end
      RT_TRAP: chk(trap_class_o == 6'h18, "R3", "trap class", DW'(trap_class_o), DW'(6'h18));
      default: ;
    endcase
    @(posedge clk_i); @(negedge clk_i);
    chk(!(out_direct_o | out_redir_o | out_trap_o | out_undef_o), "R8", "pulse length",
        DW'({out_direct_o, out_redir_o, out_trap_o, out_undef_o}), '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(req_ready_o && !mem_valid_o && !rsp_valid_o &&
        !(out_direct_o | out_redir_o | out_trap_o | out_undef_o), "R9", "reset outputs",
        DW'({req_ready_o, mem_valid_o, rsp_valid_o}), DW'(3'b100));
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_req(2'd3, 1, 1, 0, 0, 0, '0);                      // R9 register reads zero
    do_req(2'd0, 1, 1, 1, 1, 1, 64'hDEAD);                // R1
    do_req(2'd2, 1, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF); // R5 full write
    do_req(2'd3, 1, 0, 0, 0, 0, '0);
    do_req(2'd1, 1, 1, 0, 1, 1, 64'h1);                   // R4 secondary only
    do_req(2'd1, 1, 0, 1, 1, 1, 64'h2);                   // R4 level 2 disabled
    do_req(2'd1, 0, 1, 1, 1, 0, '0);                      // R4 level 2 absent
    do_req(2'd1, 1, 1, 1, 0, 1, 64'h3);                   // R3
    do_req(2'd1, 1, 1, 1, 1, 1, 64'hA5A5_0000_1234_5678); // R2 write
    do_req(2'd1, 1, 1, 1, 1, 0, '0);                      // R7 read
    do_req(2'd3, 0, 0, 0, 0, 1, 64'h5555);                // R6 write ignored
    do_req(2'd3, 0, 0, 0, 0, 0, '0);                      // R6 reads zero
    do_req(2'd3, 1, 1, 0, 0, 0, '0);                      // R6 old value kept
    do_req(2'd2, 0, 1, 0, 0, 1, 64'h7);                   // R6 level 2 undefined
    do_req(2'd2, 1, 1, 0, 0, 0, '0);
    for (int n = 0; n < 400; n++) begin
      do_req(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             1'($urandom), {$urandom, $urandom});
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule